// File: doc/BRIEF.md
# Dual-Match Reloading Down-Counter Channel

A single timer channel that counts down by one on each selected tick. When the count reaches zero, the next tick loads it again from a programmable reload value, so the channel runs periodically. Two match values, which may be programmed in either order, mark points inside each period. A zero event marks the end of the period. Every event inverts one shared interrupt level. The interrupt is not pulsed, so software sees an edge on each event.

Two tick strobes reach the channel: a fast bus-rate strobe (24 MHz nominal) and a slow external strobe (1 MHz nominal). One control bit selects between them. The live count and the stored reload and match values come back out on plain outputs. Bus decoding, the grouping of several channels and waveform generation belong to the surrounding logic. Every pin is a plain control or status signal: no data stream passes through the block, so it has no valid/ready handshake.

Top module: `dual_match_downcounter`

## Requirements
- R1: On each clock edge where the channel is enabled, the selected tick is high and no write strobe is high, a nonzero count decrements by one. A zero count loads the reload value, and that load raises no event.
- R2: `ctl_slow_sel` = 0 selects `tick_fast` and `ctl_slow_sel` = 1 selects `tick_slow`. The strobe that is not selected has no effect on the count.
- R3: A match event occurs when a decrement lands on a match value that is nonzero and not above the reload value. The two matches may be in either order. Two events on the same decrement invert the interrupt once.
- R4: A decrement that lands on zero raises an event when `ctl_zero_irq_en` is 1 or when either match value is zero.
- R5: Each event inverts `irq_level` on the same clock edge that updates `count_q`.
- R6: With a reload value of zero, the count holds at zero and raises no further events. Writing a nonzero reload while the stored reload is zero and the channel is enabled loads that value into the count on the same edge.
- R7: A count write while the channel is enabled loads `wr_data` into the count. A count write while the channel is disabled is ignored.
- R8: A 0-to-1 transition of `ctl_run` loads the count from the reload value, using a reload written in the same cycle if there is one. While `ctl_run` is 0, the count and `irq_level` hold.
- R9: After reset, the count, the reload value, both match values and `irq_level` are all zero.
- R10: `reload_q`, `match_a_q` and `match_b_q` return the last value written to each.
- R11: A match value greater than the reload value never raises an event.
- R12: In a cycle where any write strobe is high, the tick is dropped and the register write is applied instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Fast bus-rate tick strobe |
| tick_slow | input | 1 | Slow external tick strobe |
| ctl_run | input | 1 | Channel enable |
| ctl_slow_sel | input | 1 | Tick select: 1 selects the slow strobe |
| ctl_zero_irq_en | input | 1 | Raise an event when the count reaches zero |
| wr_count | input | 1 | Write strobe for the count |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_match_a | input | 1 | Write strobe for match A |
| wr_match_b | input | 1 | Write strobe for match B |
| wr_data | input | W | Write data for every strobe |
| count_q | output | W | Live count |
| reload_q | output | W | Stored reload value |
| match_a_q | output | W | Stored match A |
| match_b_q | output | W | Stored match B |
| irq_level | output | 1 | Interrupt level, inverted on each event |

## Verification
A wrong count shows on `count_q` on the first edge after the fault, and a wrong period shows one edge after the wrap. A missing or duplicated event leaves `irq_level` in the wrong phase from that edge on. The phase error persists until another error cancels it, so the bench compares the level after every single tick, not only at the end of each period. The sweep covers all orderings of two small match values against small reload values, including matches above the reload and matches at zero.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_WRITE,
    ACT_START,
    ACT_DEC,
    ACT_WRAP
  } cnt_act_e;
  localparam int NMATCH = 2;
endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel (
  input  logic slow_sel,
  input  logic tick_fast,
  input  logic tick_slow,
  output logic tick
);
  always_comb tick = slow_sel ? tick_slow : tick_fast;
endmodule

// File: rtl/dmt_event_eval.sv
module dmt_event_eval #(
  parameter int W  = 32,
  parameter int NM = 2
) (
  input  logic [W-1:0] next_val,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] match_val [NM],
  input  logic         zero_en,
  output logic         hit
);
  logic [NM-1:0] m_hit;
  logic [NM-1:0] m_zero;
  logic          z_hit;

  // one comparator per match; order of the matches is irrelevant since
  // the count visits the larger one first on its way down
  for (genvar i = 0; i < NM; i++) begin : g_cmp
    always_comb begin
      m_zero[i] = (match_val[i] == '0);
      m_hit[i]  = !m_zero[i] && (match_val[i] <= reload_val) &&
                  (next_val == match_val[i]);
    end
  end

  always_comb begin
    z_hit = (next_val == '0) && (zero_en || (|m_zero));
    hit   = z_hit || (|m_hit);
  end
endmodule

// File: rtl/dual_match_downcounter.sv
module dual_match_downcounter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_fast,
  input  logic         tick_slow,
  input  logic         ctl_run,
  input  logic         ctl_slow_sel,
  input  logic         ctl_zero_irq_en,
  input  logic         wr_count,
  input  logic         wr_reload,
  input  logic         wr_match_a,
  input  logic         wr_match_b,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_q,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] match_a_q,
  output logic [W-1:0] match_b_q,
  output logic         irq_level
);
  import dmt_pkg::*;

  logic [W-1:0] cnt_r, rld_r, rld_nx, dec_val, load_val;
  logic [W-1:0] mt_r [NMATCH];
  logic         lvl_r, run_d;
  logic         tick, any_wr, tick_go, evt_hit, refill;
  cnt_act_e     act;

  dmt_tick_sel u_tsel (
    .slow_sel  (ctl_slow_sel),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .tick      (tick)
  );

  always_comb begin
    any_wr  = wr_count | wr_reload | wr_match_a | wr_match_b;
    tick_go = ctl_run & tick & ~any_wr;
    rld_nx  = wr_reload ? wr_data : rld_r;
    dec_val = cnt_r - 1'b1;
    refill  = wr_reload && (rld_r == '0) && (wr_data != '0);
  end

  dmt_event_eval #(.W(W), .NM(NMATCH)) u_eval (
    .next_val   (dec_val),
    .reload_val (rld_r),
    .match_val  (mt_r),
    .zero_en    (ctl_zero_irq_en),
    .hit        (evt_hit)
  );

  // priority: count write, then start/refill, then tick
  always_comb begin
    act      = ACT_HOLD;
    load_val = rld_nx;
    if (ctl_run) begin
      if (wr_count) begin
        act      = ACT_WRITE;
        load_val = wr_data;
      end else if (!run_d || refill) begin
        act = ACT_START;
      end else if (tick_go) begin
        if (cnt_r != '0)      act = ACT_DEC;
        else if (rld_r != '0) act = ACT_WRAP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r <= '0;
      rld_r <= '0;
      lvl_r <= 1'b0;
      run_d <= 1'b0;
      for (int i = 0; i < NMATCH; i++) mt_r[i] <= '0;
    end else begin
      run_d <= ctl_run;
      rld_r <= rld_nx;
      if (wr_match_a) mt_r[0] <= wr_data;
      if (wr_match_b) mt_r[1] <= wr_data;
      unique case (act)
        ACT_WRITE, ACT_START: cnt_r <= load_val;
        ACT_DEC:              cnt_r <= dec_val;
        ACT_WRAP:             cnt_r <= rld_r;
        default:              cnt_r <= cnt_r;
      endcase
      if (act == ACT_DEC && evt_hit) lvl_r <= ~lvl_r;
    end
  end

  assign count_q   = cnt_r;
  assign reload_q  = rld_r;
  assign match_a_q = mt_r[0];
  assign match_b_q = mt_r[1];
  assign irq_level = lvl_r;
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_fast,
  input logic         tick_slow,
  input logic         ctl_run,
  input logic         ctl_slow_sel,
  input logic         wr_count,
  input logic         wr_reload,
  input logic         wr_match_a,
  input logic         wr_match_b,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count_q,
  input logic [W-1:0] reload_q,
  input logic         irq_level
);
  logic sel_tick, quiet;
  always_comb begin
    sel_tick = ctl_slow_sel ? tick_slow : tick_fast;
    quiet    = !(wr_count || wr_reload || wr_match_a || wr_match_b);
  end

  // R8
  count_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_run |=> $stable(count_q));

  // R8
  irq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_run |=> $stable(irq_level));

  // R7
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && wr_count) |=> (count_q == $past(wr_data)));

  // R1
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && $past(ctl_run) && $past(rst_n) && sel_tick && quiet && count_q != '0)
      |=> (count_q == $past(count_q) - 1'b1));

  // R1
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && $past(ctl_run) && $past(rst_n) && sel_tick && quiet && count_q == '0)
      |=> (count_q == $past(reload_q)));

  // R10
  reload_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> (reload_q == $past(wr_data)));
endmodule

bind dual_match_downcounter dmt_checker #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_fast    (tick_fast),
  .tick_slow    (tick_slow),
  .ctl_run      (ctl_run),
  .ctl_slow_sel (ctl_slow_sel),
  .wr_count     (wr_count),
  .wr_reload    (wr_reload),
  .wr_match_a   (wr_match_a),
  .wr_match_b   (wr_match_b),
  .wr_data      (wr_data),
  .count_q      (count_q),
  .reload_q     (reload_q),
  .irq_level    (irq_level)
);

// File: tb/sim_dual_match_downcounter.sv
module sim_dual_match_downcounter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_fast = 0, tick_slow = 0, ctl_run = 0, ctl_slow_sel = 0, ctl_zero_irq_en = 0;
  logic wr_count = 0, wr_reload = 0, wr_match_a = 0, wr_match_b = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count_q, reload_q, match_a_q, match_b_q;
  logic irq_level;

  int n_chk = 0, n_fail = 0;

  // reference state built from the requirements
  logic [W-1:0] m_cnt = '0, m_rld = '0, m_ma = '0, m_mb = '0;
  logic m_lvl = 0, m_rund = 0;

  always #2 clk = ~clk;

  dual_match_downcounter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .ctl_run(ctl_run), .ctl_slow_sel(ctl_slow_sel), .ctl_zero_irq_en(ctl_zero_irq_en),
    .wr_count(wr_count), .wr_reload(wr_reload), .wr_match_a(wr_match_a),
    .wr_match_b(wr_match_b), .wr_data(wr_data), .count_q(count_q),
    .reload_q(reload_q), .match_a_q(match_a_q), .match_b_q(match_b_q),
    .irq_level(irq_level)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic mhit(input logic [W-1:0] v, input logic [W-1:0] m);
    return (m != 0) && (m <= m_rld) && (v == m);
  endfunction

  // expected next state for the inputs now applied
  task automatic model_step();
    logic any_wr, tk, evt;
    logic [W-1:0] v, nrld;
    any_wr = wr_count | wr_reload | wr_match_a | wr_match_b;
    tk     = ctl_run && !any_wr && (ctl_slow_sel ? tick_slow : tick_fast);
    nrld   = wr_reload ? wr_data : m_rld;
    evt    = 0;
    if (ctl_run) begin
      if (wr_count) m_cnt = wr_data;
      else if (!m_rund) m_cnt = nrld;
      else if (wr_reload && m_rld == 0 && wr_data != 0) m_cnt = wr_data;
      else if (tk) begin
        if (m_cnt != 0) begin
          v   = m_cnt - 1;
          evt = mhit(v, m_ma) || mhit(v, m_mb) ||
                (v == 0 && (ctl_zero_irq_en || m_ma == 0 || m_mb == 0));
          m_cnt = v;
        end else if (m_rld != 0) m_cnt = m_rld;
      end
    end
    if (evt) m_lvl = ~m_lvl;
    m_rld = nrld;
    if (wr_match_a) m_ma = wr_data;
    if (wr_match_b) m_mb = wr_data;
    m_rund = ctl_run;
  endtask

  // caller sets inputs at a falling edge; one clock, then compare
  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    #1;
    chk(tag, "count", int'(count_q), int'(m_cnt));
    chk(tag, "irq", int'(irq_level), int'(m_lvl));
    @(negedge clk);
    wr_count = 0; wr_reload = 0; wr_match_a = 0; wr_match_b = 0;
  endtask

  task automatic regs(input string tag);
    chk(tag, "reload", int'(reload_q), int'(m_rld));
    chk(tag, "match_a", int'(match_a_q), int'(m_ma));
    chk(tag, "match_b", int'(match_b_q), int'(m_mb));
  endtask

  task automatic wr(input int which, input int val, input string tag);
    wr_data = W'(val);
    case (which)
      0: wr_count = 1;
      1: wr_reload = 1;
      2: wr_match_a = 1;
      default: wr_match_b = 1;
    endcase
    cyc(tag);
  endtask

  task automatic run_main();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #0;
    // R9 reset state
    chk("R9", "count", int'(count_q), 0);
    chk("R9", "irq", int'(irq_level), 0);
    regs("R9");

    // R10 readback while disabled
    wr(1, 9, "R10"); wr(2, 3, "R10"); wr(3, 7, "R10");
    regs("R10");

    // R8 enable loads reload; R1 decrements
    ctl_run = 1; cyc("R8");
    tick_fast = 1;
    for (int i = 0; i < 12; i++) cyc("R1");
    ctl_run = 0;
    for (int i = 0; i < 4; i++) cyc("R8");

    // R2 slow select ignores the fast strobe
    ctl_run = 1; ctl_slow_sel = 1; tick_slow = 0; cyc("R2");
    for (int i = 0; i < 3; i++) cyc("R2");
    tick_slow = 1;
    for (int i = 0; i < 3; i++) cyc("R2");
    ctl_slow_sel = 0;

    // R7 and R12: count write beats the tick
    wr(0, 5, "R12");
    cyc("R7");
    ctl_run = 0; wr(0, 2, "R7"); cyc("R7");

    // R6 zero reload: counter parks at zero, nonzero reload restarts it
    wr(1, 0, "R6");
    ctl_run = 1;
    for (int i = 0; i < 6; i++) cyc("R6");
    wr(1, 4, "R6");
    for (int i = 0; i < 6; i++) cyc("R6");
    regs("R10");

    // sweep: all reload/match combinations of a small range
    tick_fast = 0;
    for (int r = 0; r < 6; r++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++) begin
          string tag;
          tag = (a > r || b > r) ? "R11" : ((a == 0 || b == 0) ? "R4" : "R3");
          ctl_run = 0; tick_fast = 0;
          ctl_zero_irq_en = logic'((a + b + r) % 2);
          wr(1, r, tag); wr(2, a, tag); wr(3, b, tag);
          ctl_run = 1; cyc("R8");
          tick_fast = 1;
          for (int k = 0; k < 2 * (r + 1) + 2; k++) cyc(tag);
          if (r == 0) cyc("R6");
          cyc("R5");
        end
    tick_fast = 0; ctl_run = 0;
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule